// File: doc/BRIEF.md
# Path-Associative Trace Line Store

This block sits beside the fetch stage and keeps complete trace lines, which are short dynamic runs of instructions that may span several basic blocks. Each fetch request brings a program counter and a vector of predicted branch directions. A line is found only when its start address matches and its recorded branch directions agree with the prediction. Because of this, two or more traces can start at the same address and follow different paths, and all of them can stay resident. On a hit the block returns the stored instruction slots, the count of valid instructions, and the address where fetch continues. On a miss it pulses a build request that carries the missing address, so that a fill unit can build the trace. Finished traces come back to the block through a write port.

The array is set-associative. By default the set index is the low bits of the start address. If `XOR_INDEX` is set, the prediction bits are XOR-folded into that slice. In that mode the fill unit must write a trace with the same prediction vector that later lookups will present. A `flush` input marks the current lookup as belonging to a mispredicted path. That lookup is dropped, and the fetch unit stops taking slots from the trace it was reading.

Top module: `trace_lookup`

## Requirements
- R1: After reset, `rsp_hit` and `build_req` are low and every line is invalid, so the first lookup of any address misses.
- R2: A lookup hits only a valid line with an equal start address whose low `brcnt` prediction bits equal the request's bits `[brcnt-1:0]`. Prediction bits at or above the stored branch count are ignored. When several lines qualify, the lowest-numbered way wins.
- R3: Lines with the same start address and different branch directions are resident at the same time, and each is returned for its own prediction.
- R4: A lookup presented with `req_valid` high and `flush` low is answered at the next rising edge. On a hit, `rsp_len` and `rsp_slots` carry the stored values.
- R5: On a hit, `rsp_next_pc` is the stored target address when the branch count is nonzero and the stored direction bit `[brcnt-1]` is 1 (taken). Otherwise it is the stored fall-through address.
- R6: On a miss, `build_req` is high for exactly one cycle and `build_pc` holds the requested address.
- R7: A lookup made while `flush` is high produces neither a hit nor a build request, and it does not change replacement state.
- R8: A write picks its way in this order: a valid line with equal address, equal branch count and equal masked directions is overwritten; otherwise the lowest invalid way is used; otherwise the tree pseudo-LRU victim is used. In the tree, node 0 is the root, the children of node n are 2n+1 and 2n+2, and a 0 bit points to the lower half as the victim side.
- R9: A hitting lookup and a write each make their way the most recently used one. When both touch the same set in the same cycle, the write's update is applied on top of the lookup's update, and the victim is chosen from the state before that cycle.
- R10: A write and a lookup to the same set in the same cycle see the old contents. A lookup of the line being written misses, and the next lookup hits.
- R11: With the default concatenation index, the set is `req_pc[IDX_W-1:0]`. Addresses that differ only above those bits compete for the ways of one set, and addresses with different low bits do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Lookup request |
| req_pc | input | PC_W | Fetch address of the lookup |
| req_pred | input | MAX_BR | Predicted directions, bit i for the i-th branch, 1 = taken |
| flush | input | 1 | Misprediction; drops the current lookup |
| wr_en | input | 1 | Write a completed trace |
| wr_pc | input | PC_W | Start address of the written trace |
| wr_pred | input | MAX_BR | Branch directions recorded in the trace |
| wr_brcnt | input | CNT_W | Number of branches in the trace (0 to MAX_BR) |
| wr_len | input | LEN_W | Number of valid instruction slots |
| wr_slots | input | SLOTS*INSN_W | Instruction slots, slot 0 in the low bits |
| wr_fall_pc | input | PC_W | Address that follows the trace when not redirected |
| wr_target_pc | input | PC_W | Taken target of the last branch |
| rsp_hit | output | 1 | Lookup hit, one cycle after the request |
| rsp_len | output | LEN_W | Valid slot count of the hit line |
| rsp_slots | output | SLOTS*INSN_W | Instruction slots of the hit line |
| rsp_next_pc | output | PC_W | Next fetch address after the hit line |
| build_req | output | 1 | Miss pulse asking for a new trace |
| build_pc | output | PC_W | Address the new trace starts at |

## Verification
The directed patterns focus on distinguishing paths. Two traces from one start address are looked up with prediction vectors whose unused high bits are set, which shows masked comparison apart from exact comparison. A trace with no branches and a two-branch trace whose last branch is taken check the next-address selection. A run of five traces with the same low address bits, with a lookup in the middle, tells tree pseudo-LRU apart from true LRU and from round-robin, because the evicted line is a different one under each policy. Random traffic draws from a small pool of addresses and mixes lookups, writes, flushes and same-set collisions, so overwrites, evictions and old-data reads all occur often and are compared against a reference model of the array.

// File: rtl/trace_lookup.sv
module trace_lookup #(
  parameter int PC_W      = 16,
  parameter int SETS      = 8,
  parameter int WAYS      = 4,
  parameter int MAX_BR    = 3,
  parameter int SLOTS     = 4,
  parameter int INSN_W    = 16,
  parameter bit XOR_INDEX = 1'b0,
  localparam int IDX_W  = $clog2(SETS),
  localparam int LVL    = $clog2(WAYS),
  localparam int CNT_W  = $clog2(MAX_BR + 1),
  localparam int LEN_W  = $clog2(SLOTS + 1),
  localparam int LINE_W = SLOTS * INSN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [PC_W-1:0]   req_pc,
  input  logic [MAX_BR-1:0] req_pred,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [PC_W-1:0]   wr_pc,
  input  logic [MAX_BR-1:0] wr_pred,
  input  logic [CNT_W-1:0]  wr_brcnt,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic [LINE_W-1:0] wr_slots,
  input  logic [PC_W-1:0]   wr_fall_pc,
  input  logic [PC_W-1:0]   wr_target_pc,
  output logic              rsp_hit,
  output logic [LEN_W-1:0]  rsp_len,
  output logic [LINE_W-1:0] rsp_slots,
  output logic [PC_W-1:0]   rsp_next_pc,
  output logic              build_req,
  output logic [PC_W-1:0]   build_pc
);

  logic [WAYS-1:0]   vld_q  [SETS];
  logic [WAYS-2:0]   tree_q [SETS];
  logic [PC_W-1:0]   pc_q   [SETS][WAYS];
  logic [MAX_BR-1:0] dir_q  [SETS][WAYS];
  logic [CNT_W-1:0]  cnt_q  [SETS][WAYS];
  logic [LEN_W-1:0]  len_q  [SETS][WAYS];
  logic [LINE_W-1:0] slot_q [SETS][WAYS];
  logic [PC_W-1:0]   fall_q [SETS][WAYS];
  logic [PC_W-1:0]   tgt_q  [SETS][WAYS];

  function automatic logic [IDX_W-1:0] set_of(input logic [PC_W-1:0] pc,
                                               input logic [MAX_BR-1:0] pr);
    logic [IDX_W-1:0] r;
    r = pc[IDX_W-1:0];
    if (XOR_INDEX)
      for (int i = 0; i < MAX_BR; i++) r[i % IDX_W] = r[i % IDX_W] ^ pr[i];
    return r;
  endfunction

  function automatic logic [MAX_BR-1:0] mask_of(input logic [CNT_W-1:0] c);
    logic [MAX_BR-1:0] m;
    for (int i = 0; i < MAX_BR; i++) m[i] = (i < int'(c));
    return m;
  endfunction

  function automatic logic [WAYS-2:0] touch(input logic [WAYS-2:0] t,
                                            input logic [LVL-1:0] way);
    logic [WAYS-2:0] r;
    int n;
    r = t;
    n = 0;
    for (int l = 0; l < LVL; l++) begin
      r[n] = ~way[LVL-1-l];
      n = 2 * n + 1 + int'(way[LVL-1-l]);
    end
    return r;
  endfunction

  function automatic logic [LVL-1:0] victim(input logic [WAYS-2:0] t);
    logic [LVL-1:0] w;
    int n;
    w = '0;
    n = 0;
    for (int l = 0; l < LVL; l++) begin
      w[LVL-1-l] = t[n];
      n = 2 * n + 1 + int'(t[n]);
    end
    return w;
  endfunction

  wire [IDX_W-1:0] lk_set = set_of(req_pc, req_pred);
  wire [IDX_W-1:0] wr_set = set_of(wr_pc, wr_pred);
  wire [MAX_BR-1:0] wr_dir = wr_pred & mask_of(wr_brcnt);
  wire lk_go = req_valid && !flush;

  logic [WAYS-1:0] lk_match, wr_match;
  logic [LVL-1:0]  lk_way, wr_way;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign lk_match[w] = vld_q[lk_set][w] && pc_q[lk_set][w] == req_pc &&
      ((dir_q[lk_set][w] ^ req_pred) & mask_of(cnt_q[lk_set][w])) == '0;
    assign wr_match[w] = vld_q[wr_set][w] && pc_q[wr_set][w] == wr_pc &&
      cnt_q[wr_set][w] == wr_brcnt && dir_q[wr_set][w] == wr_dir;
  end

  wire lk_hit = |lk_match;

  always_comb begin
    lk_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (lk_match[w]) lk_way = LVL'(w);
  end

  always_comb begin
    wr_way = victim(tree_q[wr_set]);
    if (|wr_match) begin
      for (int w = WAYS - 1; w >= 0; w--)
        if (wr_match[w]) wr_way = LVL'(w);
    end else if (!(&vld_q[wr_set])) begin
      for (int w = WAYS - 1; w >= 0; w--)
        if (!vld_q[wr_set][w]) wr_way = LVL'(w);
    end
  end

  wire [CNT_W-1:0]  hit_cnt = cnt_q[lk_set][lk_way];
  wire [MAX_BR-1:0] hit_dir = dir_q[lk_set][lk_way];
  wire hit_taken = (hit_cnt != '0) && hit_dir[hit_cnt - CNT_W'(1)];

  wire lk_touch = lk_go && lk_hit;
  wire [WAYS-2:0] wr_base = (lk_touch && lk_set == wr_set) ?
                            touch(tree_q[lk_set], lk_way) : tree_q[wr_set];

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_hit   <= 1'b0;
      build_req <= 1'b0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        tree_q[s] <= '0;
      end
    end else begin
      rsp_hit   <= lk_touch;
      build_req <= lk_go && !lk_hit;
      if (lk_touch) tree_q[lk_set] <= touch(tree_q[lk_set], lk_way);
      if (wr_en) begin
        vld_q[wr_set][wr_way] <= 1'b1;
        tree_q[wr_set]        <= touch(wr_base, wr_way);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (lk_go) build_pc <= req_pc;
    if (lk_touch) begin
      rsp_len     <= len_q[lk_set][lk_way];
      rsp_slots   <= slot_q[lk_set][lk_way];
      rsp_next_pc <= hit_taken ? tgt_q[lk_set][lk_way] : fall_q[lk_set][lk_way];
    end
    if (wr_en) begin
      pc_q[wr_set][wr_way]   <= wr_pc;
      dir_q[wr_set][wr_way]  <= wr_dir;
      cnt_q[wr_set][wr_way]  <= wr_brcnt;
      len_q[wr_set][wr_way]  <= wr_len;
      slot_q[wr_set][wr_way] <= wr_slots;
      fall_q[wr_set][wr_way] <= wr_fall_pc;
      tgt_q[wr_set][wr_way]  <= wr_target_pc;
    end
  end

endmodule

// File: rtl/trace_lookup_chk.sv
module trace_lookup_chk #(
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            flush,
  input logic [PC_W-1:0] req_pc,
  input logic            rsp_hit,
  input logic            build_req,
  input logic [PC_W-1:0] build_pc
);

  p_one_answer_r4: assert property (@(posedge clk) disable iff (rst)
    !(rsp_hit && build_req));

  p_answered_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !flush) |=> (rsp_hit || build_req));

  p_no_unasked_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_hit || build_req) |-> $past(req_valid && !flush));

  p_flush_drops_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && flush) |=> !(rsp_hit || build_req));

  p_build_addr_r6: assert property (@(posedge clk) disable iff (rst)
    build_req |-> build_pc == $past(req_pc));

endmodule

bind trace_lookup trace_lookup_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .flush(flush), .req_pc(req_pc),
  .rsp_hit(rsp_hit), .build_req(build_req), .build_pc(build_pc)
);

// File: tb/test_trace_lookup.sv
module test_trace_lookup;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 16, SETS = 8, WAYS = 4, MAX_BR = 3, SLOTS = 4, INSN_W = 16;
  localparam int CNT_W = 2, LEN_W = 3, LINE_W = SLOTS * INSN_W;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, flush = 1'b0, wr_en = 1'b0;
  logic [PC_W-1:0] req_pc = '0, wr_pc = '0, wr_fall_pc = '0, wr_target_pc = '0;
  logic [MAX_BR-1:0] req_pred = '0, wr_pred = '0;
  logic [CNT_W-1:0] wr_brcnt = '0;
  logic [LEN_W-1:0] wr_len = '0;
  logic [LINE_W-1:0] wr_slots = '0;
  logic rsp_hit, build_req;
  logic [LEN_W-1:0] rsp_len;
  logic [LINE_W-1:0] rsp_slots;
  logic [PC_W-1:0] rsp_next_pc, build_pc;

  always #(CLK_PERIOD / 2) clk = ~clk;

  trace_lookup i_trace_lookup (.*);

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference model of the array
  bit          m_v    [SETS][WAYS];
  int          m_tree [SETS][WAYS-1];
  logic [PC_W-1:0]   m_pc [SETS][WAYS], m_fall [SETS][WAYS], m_tgt [SETS][WAYS];
  logic [MAX_BR-1:0] m_dir [SETS][WAYS];
  int          m_cnt  [SETS][WAYS];
  logic [LEN_W-1:0]  m_len [SETS][WAYS];
  logic [LINE_W-1:0] m_sl  [SETS][WAYS];

  function automatic int low_bits(int c);
    return (1 << c) - 1;
  endfunction

  function automatic int find(int s, logic [PC_W-1:0] pc, logic [MAX_BR-1:0] pr);
    for (int w = 0; w < WAYS; w++)
      if (m_v[s][w] && m_pc[s][w] == pc &&
          ((int'(m_dir[s][w]) ^ int'(pr)) & low_bits(m_cnt[s][w])) == 0)
        return w;
    return -1;
  endfunction

  // a tree bit equal to 1 sends the victim search to the upper half
  task automatic mark_used(int s, int w);
    int n = 0;
    for (int l = 1; l >= 0; l--) begin
      int b = (w >> l) & 1;
      m_tree[s][n] = 1 - b;
      n = 2 * n + 1 + b;
    end
  endtask

  function automatic int pick_old(int t0, int t1, int t2);
    if (t0 == 0) return t1;
    return 2 + t2;
  endfunction

  logic e_hit, e_build;
  logic [LEN_W-1:0] e_len;
  logic [LINE_W-1:0] e_sl;
  logic [PC_W-1:0] e_next, e_bpc;

  task automatic check(string tag, string what, logic [LINE_W-1:0] act, logic [LINE_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(string tag);
    int ls, ws, lw, ww, old0, old1, old2;
    ls = int'(req_pc[2:0]);
    lw = find(ls, req_pc, req_pred);
    e_hit = req_valid && !flush && lw >= 0;
    e_build = req_valid && !flush && lw < 0;
    e_bpc = req_pc;
    if (lw >= 0) begin
      e_len = m_len[ls][lw];
      e_sl = m_sl[ls][lw];
      e_next = (m_cnt[ls][lw] > 0 && m_dir[ls][lw][m_cnt[ls][lw]-1]) ? m_tgt[ls][lw] : m_fall[ls][lw];
    end
    ws = int'(wr_pc[2:0]);
    old0 = m_tree[ws][0]; old1 = m_tree[ws][1]; old2 = m_tree[ws][2];
    @(posedge clk);
    if (e_hit) mark_used(ls, lw);
    if (wr_en) begin
      logic [MAX_BR-1:0] d;
      d = wr_pred & MAX_BR'(low_bits(int'(wr_brcnt)));
      ww = -1;
      for (int w = WAYS - 1; w >= 0; w--)
        if (m_v[ws][w] && m_pc[ws][w] == wr_pc && m_cnt[ws][w] == int'(wr_brcnt) && m_dir[ws][w] == d) ww = w;
      if (ww < 0)
        for (int w = WAYS - 1; w >= 0; w--) if (!m_v[ws][w]) ww = w;
      if (ww < 0) ww = pick_old(old0, old1, old2);
      m_v[ws][ww] = 1'b1; m_pc[ws][ww] = wr_pc; m_dir[ws][ww] = d;
      m_cnt[ws][ww] = int'(wr_brcnt); m_len[ws][ww] = wr_len; m_sl[ws][ww] = wr_slots;
      m_fall[ws][ww] = wr_fall_pc; m_tgt[ws][ww] = wr_target_pc;
      mark_used(ws, ww);
    end
    @(negedge clk);
    check(tag, "rsp_hit", LINE_W'(rsp_hit), LINE_W'(e_hit));
    check(tag, "build_req", LINE_W'(build_req), LINE_W'(e_build));
    if (e_build) check(tag, "build_pc", LINE_W'(build_pc), LINE_W'(e_bpc));
    if (e_hit) begin
      check(tag, "rsp_len", LINE_W'(rsp_len), LINE_W'(e_len));
      check(tag, "rsp_slots", rsp_slots, e_sl);
      check(tag, "rsp_next_pc", LINE_W'(rsp_next_pc), LINE_W'(e_next));
    end
  endtask

  task automatic set_look(bit v, logic [PC_W-1:0] pc, logic [MAX_BR-1:0] pr, bit fl);
    req_valid = v; req_pc = pc; req_pred = pr; flush = fl;
  endtask

  task automatic set_fill(bit v, logic [PC_W-1:0] pc, logic [MAX_BR-1:0] pr, int c,
                          int len, logic [PC_W-1:0] fall, logic [PC_W-1:0] tgt);
    wr_en = v; wr_pc = pc; wr_pred = pr; wr_brcnt = CNT_W'(c); wr_len = LEN_W'(len);
    wr_slots = {pc ^ 16'h1111, tgt, fall, pc}; wr_fall_pc = fall; wr_target_pc = tgt;
  endtask

  task automatic look(string tag, logic [PC_W-1:0] pc, logic [MAX_BR-1:0] pr, bit fl);
    set_look(1'b1, pc, pr, fl);
    set_fill(1'b0, '0, '0, 0, 0, '0, '0);
    cyc(tag);
    set_look(1'b0, '0, '0, 1'b0);
  endtask

  task automatic fill(string tag, logic [PC_W-1:0] pc, logic [MAX_BR-1:0] pr, int c,
                      int len, logic [PC_W-1:0] fall, logic [PC_W-1:0] tgt);
    set_look(1'b0, '0, '0, 1'b0);
    set_fill(1'b1, pc, pr, c, len, fall, tgt);
    cyc(tag);
    set_fill(1'b0, '0, '0, 0, 0, '0, '0);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R4: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed7);
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) m_v[s][w] = 1'b0;
      for (int n = 0; n < WAYS - 1; n++) m_tree[s][n] = 0;
    end
    repeat (3) @(negedge clk);
    check("R1", "rsp_hit in reset", LINE_W'(rsp_hit), '0);
    check("R1", "build_req in reset", LINE_W'(build_req), '0);
    rst = 1'b0;
    look("R1 R6 first lookup misses", 16'h0010, 3'b000, 1'b0);
    check("R6", "build_pc", LINE_W'(build_pc), LINE_W'(16'h0010));
    cyc("R6 single pulse");
    check("R6", "build_req drops", LINE_W'(build_req), '0);

    fill("R3", 16'h0100, 3'b001, 1, 3, 16'h0104, 16'h0500);
    fill("R3", 16'h0100, 3'b000, 1, 2, 16'h0108, 16'h0600);
    look("R2 R3 taken path, high bits ignored", 16'h0100, 3'b111, 1'b0);
    check("R5", "next pc taken", LINE_W'(rsp_next_pc), LINE_W'(16'h0500));
    look("R2 R3 not-taken path", 16'h0100, 3'b110, 1'b0);
    check("R5", "next pc fall", LINE_W'(rsp_next_pc), LINE_W'(16'h0108));
    look("R2 address mismatch", 16'h0200, 3'b001, 1'b0);

    fill("R5", 16'h0101, 3'b111, 0, 4, 16'h0111, 16'h0777);
    look("R5 no branch", 16'h0101, 3'b101, 1'b0);
    check("R5", "no branch uses fall", LINE_W'(rsp_next_pc), LINE_W'(16'h0111));
    fill("R5", 16'h0103, 3'b010, 2, 4, 16'h0113, 16'h0888);
    look("R5 last of two taken", 16'h0103, 3'b110, 1'b0);
    check("R5", "second branch taken", LINE_W'(rsp_next_pc), LINE_W'(16'h0888));
    look("R2 first branch differs", 16'h0103, 3'b011, 1'b0);

    fill("R8 overwrite", 16'h0100, 3'b101, 1, 1, 16'h0104, 16'h0abc);
    look("R8 overwritten line", 16'h0100, 3'b001, 1'b0);
    check("R8", "new target", LINE_W'(rsp_next_pc), LINE_W'(16'h0abc));

    set_look(1'b1, 16'h0102, 3'b000, 1'b0);
    set_fill(1'b1, 16'h0102, 3'b000, 0, 2, 16'h0122, 16'h0133);
    cyc("R10 same-cycle write");
    check("R10", "old contents miss", LINE_W'(rsp_hit), '0);
    look("R10 next lookup hits", 16'h0102, 3'b000, 1'b0);

    look("R7 flushed lookup", 16'h0102, 3'b000, 1'b1);
    check("R7", "no build on flush", LINE_W'(build_req), '0);

    fill("R11", 16'h0005, 3'b000, 0, 1, 16'h1005, 16'h2005);
    fill("R11", 16'h0105, 3'b000, 0, 1, 16'h1105, 16'h2105);
    fill("R11", 16'h0205, 3'b000, 0, 1, 16'h1205, 16'h2205);
    fill("R11", 16'h0305, 3'b000, 0, 1, 16'h1305, 16'h2305);
    look("R9 touch way 0", 16'h0005, 3'b000, 1'b0);
    fill("R8 R9 evict", 16'h0405, 3'b000, 0, 1, 16'h1405, 16'h2405);
    look("R9", 16'h0005, 3'b000, 1'b0);
    check("R9", "recently used kept", LINE_W'(rsp_hit), LINE_W'(1));
    look("R9", 16'h0105, 3'b000, 1'b0);
    check("R9", "tree keeps way 1", LINE_W'(rsp_hit), LINE_W'(1));
    look("R8", 16'h0205, 3'b000, 1'b0);
    check("R8", "tree victim way 2 evicted", LINE_W'(rsp_hit), '0);
    look("R11 other set untouched", 16'h0101, 3'b000, 1'b0);
    check("R11", "set 1 line kept", LINE_W'(rsp_hit), LINE_W'(1));

    for (int i = 0; i < 4000; i++) begin
      logic [PC_W-1:0] lp, wp;
      lp = PC_W'((($urandom % 3) << 8) | ($urandom % 8));
      wp = PC_W'((($urandom % 3) << 8) | ($urandom % 8));
      set_look(($urandom % 10) < 7, lp, MAX_BR'($urandom), ($urandom % 20) == 0);
      set_fill(($urandom % 10) < 4, wp, MAX_BR'($urandom), int'($urandom % 4),
               1 + int'($urandom % 4), PC_W'($urandom), PC_W'($urandom));
      cyc("R2 R4 R5 R8 R9 R10 random");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule